// File: doc/BRIEF.md
# Memory Test Pattern Write Engine

This block is the write half of a built-in self-test for a word-addressed memory. Software programs a byte start address, a byte end address, a byte length and a data-source choice, then pulses a start input. The engine captures that configuration and issues one write per generated word through a valid/ready write port. Each word holds either a running counter value or the state of a pseudo-random shift register.

Word addresses are taken relative to the base word. The word index is masked with one less than the end-minus-base distance, so a run longer than the window wraps and later words overwrite earlier locations. That distance is expected to be a power of two. When every word has been accepted, the engine holds a done flag until the next start.

Top module: `pattern_writer`

## Requirements
- R1: During and right after reset, `wrValid`, `busy` and `done` are all low.
- R2: A run issues exactly `cfgLength / (DATA_W/8)` accepted writes, rounded down. Trailing bytes that do not fill a word are dropped.
- R3: With `cfgRandom` low, the data of write n (counting from 0) is n, zero-extended to the full word.
- R4: The first write goes to word index `cfgBase / (DATA_W/8)`, rounded down.
- R5: Write n goes to word `baseWord + (n & (cfgEnd - cfgBase - 1))`, modulo the word address space. A run longer than the window therefore overwrites the window from its start.
- R6: With `cfgRandom` high, write 0 carries the seed (default 0xA5 repeated in every byte). Each accepted write then advances a left-shifting Fibonacci register whose new bit 0 is the XOR of bits 31, 21, 1 and 0 (32-bit width). The seed is reloaded on every start, and the values written are not a +1 sequence.
- R7: While words remain, `wrValid` is high. It stays high, with `wrAddr` and `wrData` unchanged, through every cycle in which `wrReady` is low.
- R8: `done` rises in the cycle after the last accepted write, together with `wrValid` and `busy` falling. It stays high until the next start. `busy` is high from the cycle after start until the last write is accepted.
- R9: A start pulse while busy is ignored. Configuration inputs are sampled only on an accepted start, so changing them during a run has no effect.
- R10: A length below one word produces no writes, and `done` rises in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a run when not busy |
| cfgBase | input | ADDR_W | Start byte address |
| cfgEnd | input | ADDR_W | End byte address; end minus base sets the wrap mask |
| cfgLength | input | LEN_W | Run length in bytes |
| cfgRandom | input | 1 | 1 = pseudo-random data, 0 = counter data |
| wrValid | output | 1 | Write request |
| wrReady | input | 1 | Memory accepts the write this cycle |
| wrAddr | output | ADDR_W - log2(DATA_W/8) | Word address of the write |
| wrData | output | DATA_W | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |

## Verification
A corrupted word counter shows up on the very next presented write as a wrong counter value or a wrong masked address. It also moves the cycle in which `done` rises, so the bench compares every presented address and data word and the exact done cycle against arithmetic expectations. A wrong wrap mask or base conversion only becomes visible once the index passes the window. For that reason the sweeps run lengths past one and two windows and compare a full memory image after each run. A random-source fault appears on the second write.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef struct packed {
    logic load;     // capture configuration, clear index, reseed
    logic advance;  // accepted write: step index and random source
  } pgStrobes_t;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_DONE = 2'd2
  } pgState_e;

endpackage

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 12,
  parameter logic [DATA_W-1:0] SEED = {(DATA_W/8){8'hA5}},
  localparam int BYTES   = DATA_W / 8,
  localparam int SHIFT   = $clog2(BYTES),
  localparam int WADDR_W = ADDR_W - SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  pgStrobes_t         strobes,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [ADDR_W-1:0]  cfgEnd,
  input  logic [LEN_W-1:0]   cfgLength,
  input  logic               cfgRandom,
  output logic [WADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0]  wrData,
  output logic               lastWord,
  output logic               emptyReq
);

  logic [LEN_W-1:0]   lenWords;
  logic [ADDR_W-1:0]  rangeBytes;
  logic [WADDR_W-1:0] maskIn;
  logic [WADDR_W-1:0] baseWordIn;

  logic [WADDR_W-1:0] baseWordQ;
  logic [WADDR_W-1:0] maskQ;
  logic [LEN_W-1:0]   countQ;
  logic [LEN_W-1:0]   idxQ;
  logic [DATA_W-1:0]  lfsrQ;
  logic               randQ;
  logic               fb;

  // Byte quantities converted to words at load time
  assign lenWords   = LEN_W'(cfgLength >> SHIFT);
  assign rangeBytes = cfgEnd - cfgBase;
  assign maskIn     = WADDR_W'(rangeBytes - ADDR_W'(1));
  assign baseWordIn = WADDR_W'(cfgBase >> SHIFT);
  assign emptyReq   = (lenWords == '0);

  // Feedback taps chosen per supported width (maximal-length polynomials)
  generate
    if (DATA_W == 8) begin : gTap8
      assign fb = lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3];
    end else if (DATA_W == 64) begin : gTap64
      assign fb = lfsrQ[63] ^ lfsrQ[62] ^ lfsrQ[60] ^ lfsrQ[59];
    end else begin : gTap32
      assign fb = lfsrQ[31] ^ lfsrQ[21] ^ lfsrQ[1] ^ lfsrQ[0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseWordQ <= '0;
      maskQ     <= '0;
      countQ    <= '0;
      idxQ      <= '0;
      lfsrQ     <= SEED;
      randQ     <= 1'b0;
    end else if (strobes.load) begin
      baseWordQ <= baseWordIn;
      maskQ     <= maskIn;
      countQ    <= lenWords;
      idxQ      <= '0;
      lfsrQ     <= SEED;
      randQ     <= cfgRandom;
    end else if (strobes.advance) begin
      idxQ  <= idxQ + LEN_W'(1);
      lfsrQ <= {lfsrQ[DATA_W-2:0], fb};
    end
  end

  assign wrAddr   = baseWordQ + (WADDR_W'(idxQ) & maskQ);
  assign wrData   = randQ ? lfsrQ : DATA_W'(idxQ);
  assign lastWord = (idxQ == countQ - LEN_W'(1));

  // Every address stays inside the masked window above the base word
  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((wrAddr - baseWordQ) & ~maskQ) == '0);

  // The random source never collapses into the all-zero lock-up state
  assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       wrReady,
  input  logic       lastWord,
  input  logic       emptyReq,
  output pgStrobes_t strobes,
  output logic       wrValid,
  output logic       busy,
  output logic       done
);

  pgState_e stateQ, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = stateQ;
    case (stateQ)
      PG_IDLE, PG_DONE: begin
        if (startPulse) begin
          strobes.load = 1'b1;
          stateNext    = emptyReq ? PG_DONE : PG_RUN;
        end
      end
      PG_RUN: begin
        if (wrReady) begin
          strobes.advance = 1'b1;
          if (lastWord) stateNext = PG_DONE;
        end
      end
      default: stateNext = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= PG_IDLE;
    else       stateQ <= stateNext;
  end

  assign wrValid = (stateQ == PG_RUN);
  assign busy    = (stateQ == PG_RUN);
  assign done    = (stateQ == PG_DONE);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && lastWord) |=> (done && !wrValid));

  assert_busy_no_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.load);

endmodule

// File: rtl/pattern_writer.sv
module pattern_writer
  import pg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 12,
  parameter logic [DATA_W-1:0] SEED = {(DATA_W/8){8'hA5}}
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startPulse,
  input  logic [ADDR_W-1:0]                     cfgBase,
  input  logic [ADDR_W-1:0]                     cfgEnd,
  input  logic [LEN_W-1:0]                      cfgLength,
  input  logic                                  cfgRandom,
  output logic                                  wrValid,
  input  logic                                  wrReady,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    wrAddr,
  output logic [DATA_W-1:0]                     wrData,
  output logic                                  busy,
  output logic                                  done
);

  pgStrobes_t strobes;
  logic       lastWord;
  logic       emptyReq;

  pg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .wrReady   (wrReady),
    .lastWord  (lastWord),
    .emptyReq  (emptyReq),
    .strobes   (strobes),
    .wrValid   (wrValid),
    .busy      (busy),
    .done      (done)
  );

  pg_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .SEED  (SEED)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgBase  (cfgBase),
    .cfgEnd   (cfgEnd),
    .cfgLength(cfgLength),
    .cfgRandom(cfgRandom),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .lastWord (lastWord),
    .emptyReq (emptyReq)
  );

  // A stalled write keeps its address and data
  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrAddr) && $stable(wrData)));

endmodule

// File: tb/pattern_writer_tb.sv
`timescale 1ns/1ps
module pattern_writer_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 10;
  localparam int LEN_W  = 12;
  localparam int WORDS  = 256;
  localparam logic [31:0] SEED = 32'hA5A5A5A5;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startPulse;
  logic [9:0]  cfgBase, cfgEnd;
  logic [11:0] cfgLength;
  logic        cfgRandom;
  logic        wrValid, wrReady, busy, done;
  logic [7:0]  wrAddr;
  logic [31:0] wrData;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem    [WORDS];
  logic [31:0] expMem [WORDS];

  pattern_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .cfgBase(cfgBase), .cfgEnd(cfgEnd), .cfgLength(cfgLength),
    .cfgRandom(cfgRandom), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stepRand(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  // One run: byte base, window size, word count, extra bytes, mode
  task automatic runOne(input int baseB, input int win, input int words,
                        input int extra, input bit rnd, input bit disturb);
    int n = 0;
    int guard = 0;
    int baseW = (baseB / 4) % WORDS;
    logic [31:0] lf = SEED;
    logic [31:0] expD, prevD;
    int expA;
    bit ordered = 1'b1;
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; expMem[i] = '0; end
    @(negedge clk);
    cfgBase    = 10'(baseB);
    cfgEnd     = 10'((baseB + win) % 1024);
    cfgLength  = 12'(words * 4 + extra);
    cfgRandom  = rnd;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    // R9: scramble configuration once it has been captured
    cfgBase = 10'h3FF; cfgEnd = 10'h005; cfgLength = 12'd4; cfgRandom = ~rnd;
    forever begin
      #1;
      if (n == words || guard > 2000) break;
      guard++;
      expA = (baseW + (n & (win - 1))) % WORDS;
      expD = rnd ? lf : 32'(n);
      check(wrValid === 1'b1 && busy === 1'b1, "R7 valid/busy while words remain",
            {wrValid, busy}, 2'b11);
      check(wrAddr === 8'(expA), n == 0 ? "R4 first address" : "R5 address",
            wrAddr, expA);
      check(wrData === expD, rnd ? "R6 random data" : "R3 counter data",
            wrData, expD);
      if (disturb && n == 1) startPulse = 1'b1;  // R9 start while busy
      wrReady = ($urandom % 4) != 0;
      if (wrReady) begin
        mem[wrAddr]  = wrData;
        expMem[expA] = expD;
        if (n > 0 && wrData != prevD + 32'd1) ordered = 1'b0;
        prevD = wrData;
        n++;
        lf = stepRand(lf);
      end
      @(negedge clk);
      startPulse = 1'b0;
    end
    check(n == words, "R2 accepted write count", n, words);
    check(done === 1'b1 && wrValid === 1'b0 && busy === 1'b0,
          words == 0 ? "R10 done after empty run" : "R8 done after last write",
          {done, wrValid, busy}, 3'b100);
    if (rnd && words >= 3) check(!ordered, "R6 values not a +1 sequence", ordered, 0);
    for (int k = 0; k < 3; k++) begin
      wrReady = ($urandom % 2) != 0;
      @(negedge clk); #1;
    end
    check(done === 1'b1 && wrValid === 1'b0, "R8 done holds until next start",
          {done, wrValid}, 2'b10);
    begin
      bit same = 1'b1;
      for (int i = 0; i < WORDS; i++) if (mem[i] !== expMem[i]) same = 1'b0;
      check(same, "R5 final memory image with wrap", same, 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    int wlist[6];
    int blist[3];
    rstN = 1'b0; startPulse = 1'b0; wrReady = 1'b0;
    cfgBase = '0; cfgEnd = '0; cfgLength = '0; cfgRandom = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(wrValid === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
          {wrValid, busy, done}, 3'b000);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(wrValid === 1'b0 && done === 1'b0, "R1 idle after reset",
          {wrValid, done}, 2'b00);

    blist = '{0, 4 * 37 + 2, 4 * 250};
    for (int w = 1; w <= 16; w = w * 2) begin
      wlist = '{0, 1, 3, w, w + 3, 2 * w + 1};
      for (int bi = 0; bi < 3; bi++)
        for (int li = 0; li < 6; li++)
          for (int m = 0; m < 2; m++)
            runOne(blist[bi], w, wlist[li], (li + bi) % 4, m[0], 1'b0);
    end
    // R9: start pulses while a run is in progress
    runOne(12, 8, 12, 0, 1'b0, 1'b1);
    runOne(40, 4, 9, 2, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule